// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This controller sits beside a simple sequential CPU and chooses which of N interrupt request lines, if any, should turn into a vector call. Each line has a per-source enable and a per-source priority bit, where 0 means low and 1 means high. A global enable gates every call. The controller keeps one in-service flag per priority level. With these flags it lets a high-level handler preempt a low-level handler, and it stops any nesting beneath a running high-level handler.

The CPU tells the controller when it reaches an instruction boundary, when it begins a vector call (acknowledge) and when it executes a return from interrupt. Requests are registered on every clock and take part in arbitration on the next cycle. The controller only issues a call at an instruction boundary. After every return it holds off calls for exactly one instruction boundary.

The sequencer has three states. In IDLE it waits for a boundary that has an eligible winner. In CALL it drives the request and the latched index. In GAP it lets one instruction run after a return. The transitions are:
- IDLE to CALL on a boundary with the global enable set and a winner present.
- CALL to IDLE on acknowledge, or when the latched line is withdrawn.
- Any state to GAP on a return strobe. The return strobe takes precedence over acknowledge.
- GAP to IDLE on the next boundary.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `vec_req` is 0 and both in-service flags are 0.
- R2: When only the low flag is set, a pending enabled source with priority bit 1 is called at the next boundary, which preempts the low-level handler.
- R3: While the high in-service flag is set, `vec_req` stays 0 for all sources and boundaries.
- R4: A pending source whose level is equal to or below the highest level in service gets no call until that level's handler returns.
- R5: When high-level and low-level requests are eligible in the same cycle, the high-level source wins, whatever its index.
- R6: Among eligible requests of the same level, the lowest source index wins.
- R7: A request is registered on one clock edge and can win only at a boundary on a later edge. A request raised in the same cycle as a boundary is not called at that boundary.
- R8: After a return strobe, the first instruction boundary produces no call. A call can be made at the second boundary.
- R9: An acknowledge while `vec_req` is 1 sets the in-service flag of the called source's level. A return clears the high flag if it is set, and otherwise clears the low flag.
- R10: A source whose enable bit is 0 never wins. No call starts while `glb_en` is 0.
- R11: `vec_req` and `vec_idx` hold steady until acknowledge. If the called line is deasserted before acknowledge, `vec_req` falls two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Request line per source |
| irq_en | input | N_SRC | Enable per source |
| irq_hi | input | N_SRC | Priority per source (1 = high) |
| glb_en | input | 1 | Global enable for vector calls |
| insn_bound | input | 1 | CPU is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_ack | input | 1 | CPU begins the vector call |
| vec_req | output | 1 | Vector call requested |
| vec_idx | output | IDX_W | Index of the called source |
| svc_lo | output | 1 | Low level in service |
| svc_hi | output | 1 | High level in service |

## Verification
The directed cases cover the following errors and how each would show up:
- A controller that vectors at the boundary right after a return would show `vec_req` rising one boundary early.
- One that compares levels with "at or above" instead of "strictly above" would nest a second low-level handler.
- One that forgets the low flag on a high-level return would call a waiting low source while the preempted handler is still active.
- A pending high request placed behind a running high handler checks blocking.
- Simultaneous mixed-level requests with the low source at a smaller index catch arbitration that uses index before level.
- Dropping a line during CALL catches a request that never withdraws.
Random traffic against a cycle-level bench model then exercises the interaction of return strobes with pending calls.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        NS_IDLE = 2'd0,
        NS_CALL = 2'd1,
        NS_GAP  = 2'd2
    } nic_state_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } nic_lvl_e;

endpackage

// File: rtl/nic_sampler.sv
module nic_sampler #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_hi,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] hi_q
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
                hi_q[g]   <= 1'b0;
            end else begin
                pend_q[g] <= irq_req[g] & irq_en[g];
                hi_q[g]   <= irq_hi[g];
            end
        end
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] hi,
    input  logic             svc_lo,
    input  logic             svc_hi,
    output logic             win_vld,
    output logic [IDX_W-1:0] win_idx,
    output nic_lvl_e         win_lvl
);

    logic [N_SRC-1:0] hi_vec;
    logic [N_SRC-1:0] lo_vec;
    logic             hi_ok;
    logic             lo_ok;
    logic             hi_any;
    logic             lo_any;

    function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        hi_vec = pend & hi;
        lo_vec = pend & ~hi;
        hi_ok  = !svc_hi;
        lo_ok  = !svc_hi && !svc_lo;
        hi_any = (|hi_vec) && hi_ok;
        lo_any = (|lo_vec) && lo_ok;
        win_vld = hi_any || lo_any;
        if (hi_any) begin
            win_idx = first_set(hi_vec);
            win_lvl = LVL_HI;
        end else begin
            win_idx = first_set(lo_vec);
            win_lvl = LVL_LO;
        end
    end

endmodule

// File: rtl/nic_svc_track.sv
module nic_svc_track
    import nic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_en,
    input  nic_lvl_e set_lvl,
    input  logic     ret,
    output logic     svc_lo,
    output logic     svc_hi
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_lo <= 1'b0;
            svc_hi <= 1'b0;
        end else if (ret) begin
            if (svc_hi) svc_hi <= 1'b0;
            else        svc_lo <= 1'b0;
        end else if (set_en) begin
            if (set_lvl == LVL_HI) svc_hi <= 1'b1;
            else                   svc_lo <= 1'b1;
        end
    end

    AST_RET_POPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && svc_hi) |=> (!svc_hi && (svc_lo == $past(svc_lo)))); // R9
    AST_RET_POPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !svc_hi) |=> (!svc_lo && !svc_hi)); // R9
    AST_SET_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !ret && set_lvl == LVL_HI) |=> svc_hi); // R9

endmodule

// File: rtl/nic_seq.sv
module nic_seq
    import nic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_bound,
    input  logic             reti,
    input  logic             vec_ack,
    input  logic             glb_en,
    input  logic             win_vld,
    input  logic [IDX_W-1:0] win_idx,
    input  nic_lvl_e         win_lvl,
    input  logic [N_SRC-1:0] pend_q,
    input  logic             svc_lo,
    output logic             vec_req,
    output logic [IDX_W-1:0] vec_idx,
    output nic_lvl_e         call_lvl,
    output logic             take
);

    nic_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    nic_lvl_e         lvl_q, lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= NS_IDLE;
            idx_q <= '0;
            lvl_q <= LVL_LO;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        lvl_d = lvl_q;
        if (reti) begin
            st_d = NS_GAP;
        end else begin
            unique case (st_q)
                NS_IDLE: begin
                    if (insn_bound && glb_en && win_vld) begin
                        st_d  = NS_CALL;
                        idx_d = win_idx;
                        lvl_d = win_lvl;
                    end
                end
                NS_CALL: begin
                    if (vec_ack)              st_d = NS_IDLE;
                    else if (!pend_q[idx_q])  st_d = NS_IDLE;
                end
                NS_GAP: begin
                    if (insn_bound) st_d = NS_IDLE;
                end
                default: st_d = NS_IDLE;
            endcase
        end
    end

    always_comb begin
        vec_req  = (st_q == NS_CALL);
        vec_idx  = idx_q;
        call_lvl = lvl_q;
        take     = (st_q == NS_CALL) && vec_ack && !reti;
    end

    AST_CALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_ack && !reti && pend_q[vec_idx]) |=> (vec_req && $stable(vec_idx))); // R11
    AST_NEST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && svc_lo) |-> (call_lvl == LVL_HI)); // R4
    AST_GAP_AFTER_RET: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !vec_req); // R8
    AST_CALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> ($past(glb_en) && $past(insn_bound))); // R10

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] irq_hi,
    input  logic             glb_en,
    input  logic             insn_bound,
    input  logic             reti,
    input  logic             vec_ack,
    output logic             vec_req,
    output logic [IDX_W-1:0] vec_idx,
    output logic             svc_lo,
    output logic             svc_hi
);

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] hi_q;
    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    nic_lvl_e         win_lvl;
    nic_lvl_e         call_lvl;
    logic             take;

    nic_sampler #(.N_SRC(N_SRC)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .irq_hi  (irq_hi),
        .pend_q  (pend_q),
        .hi_q    (hi_q)
    );

    nic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .pend    (pend_q),
        .hi      (hi_q),
        .svc_lo  (svc_lo),
        .svc_hi  (svc_hi),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    nic_seq #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_bound (insn_bound),
        .reti       (reti),
        .vec_ack    (vec_ack),
        .glb_en     (glb_en),
        .win_vld    (win_vld),
        .win_idx    (win_idx),
        .win_lvl    (win_lvl),
        .pend_q     (pend_q),
        .svc_lo     (svc_lo),
        .vec_req    (vec_req),
        .vec_idx    (vec_idx),
        .call_lvl   (call_lvl),
        .take       (take)
    );

    nic_svc_track u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take),
        .set_lvl (call_lvl),
        .ret     (reti),
        .svc_lo  (svc_lo),
        .svc_hi  (svc_hi)
    );

    AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi |-> !vec_req); // R3
    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack && !reti) |=> (svc_lo || svc_hi)); // R9

endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  irq_en = '0;
    logic [N-1:0]  irq_hi = '0;
    logic          glb_en = 1'b0;
    logic          insn_bound = 1'b0;
    logic          reti = 1'b0;
    logic          vec_ack = 1'b0;
    logic          vec_req;
    logic [IW-1:0] vec_idx;
    logic          svc_lo;
    logic          svc_hi;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    nest_irq_ctrl #(.N_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .irq_hi(irq_hi), .glb_en(glb_en), .insn_bound(insn_bound),
        .reti(reti), .vec_ack(vec_ack), .vec_req(vec_req),
        .vec_idx(vec_idx), .svc_lo(svc_lo), .svc_hi(svc_hi)
    );

    // cycle-level expectation built from the requirements
    logic [N-1:0]  m_pend = '0;
    logic [N-1:0]  m_hiq = '0;
    int            m_st = 0;      // 0 idle, 1 call, 2 gap
    int            m_idx = 0;
    logic          m_lvl = 1'b0;
    logic          m_lo = 1'b0;
    logic          m_hs = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_hiq = '0; m_st = 0; m_idx = 0;
            m_lvl = 1'b0; m_lo = 1'b0; m_hs = 1'b0;
        end else begin
            logic wv;
            int   wi;
            logic wl;
            wv = 1'b0; wi = 0; wl = 1'b0;
            for (int i = 0; i < N; i++)
                if (!wv && m_pend[i] && m_hiq[i] && !m_hs) begin
                    wv = 1'b1; wi = i; wl = 1'b1;
                end
            for (int i = 0; i < N; i++)
                if (!wv && m_pend[i] && !m_hiq[i] && !m_hs && !m_lo) begin
                    wv = 1'b1; wi = i; wl = 1'b0;
                end
            if (reti) begin
                if (m_hs) m_hs = 1'b0; else m_lo = 1'b0;
                m_st = 2;
            end else if (m_st == 0) begin
                if (insn_bound && glb_en && wv) begin
                    m_st = 1; m_idx = wi; m_lvl = wl;
                end
            end else if (m_st == 1) begin
                if (vec_ack) begin
                    if (m_lvl) m_hs = 1'b1; else m_lo = 1'b1;
                    m_st = 0;
                end else if (!m_pend[m_idx]) begin
                    m_st = 0;
                end
            end else begin
                if (insn_bound) m_st = 0;
            end
            m_pend = irq_req & irq_en;
            m_hiq  = irq_hi;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk(vec_req == (m_st == 1), "R8", "model vec_req", int'(vec_req), int'(m_st == 1));
        if (m_st == 1)
            chk(int'(vec_idx) == m_idx, "R6", "model vec_idx", int'(vec_idx), m_idx);
        chk({svc_hi, svc_lo} == {m_hs, m_lo}, "R9", "model flags",
            int'({svc_hi, svc_lo}), int'({m_hs, m_lo}));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic expect_call(input string tag, input int idx);
        chk(vec_req == 1'b1, tag, "vec_req", int'(vec_req), 1);
        chk(int'(vec_idx) == idx, tag, "vec_idx", int'(vec_idx), idx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        irq_en = '1; glb_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!vec_req && !svc_lo && !svc_hi, "R1", "reset state",
            int'({vec_req, svc_hi, svc_lo}), 0);
        rst_n = 1'b1;
        step();
        chk(!vec_req && !svc_lo && !svc_hi, "R1", "after reset",
            int'({vec_req, svc_hi, svc_lo}), 0);

        // R7 / R6: two low requests raised together with a boundary
        irq_req = 8'h24; insn_bound = 1'b1;
        step();
        chk(vec_req == 1'b0, "R7", "same-cycle request", int'(vec_req), 0);
        step();
        expect_call("R6", 2);
        insn_bound = 1'b0; vec_ack = 1'b1;
        step();
        vec_ack = 1'b0;
        chk(svc_lo == 1'b1 && svc_hi == 1'b0, "R9", "ack low",
            int'({svc_hi, svc_lo}), 1);
        irq_req = 8'h20;

        // R4: another low source waits behind a running low handler
        insn_bound = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(vec_req == 1'b0, "R4", "low behind low", int'(vec_req), 0);
        end

        // R2: high source preempts
        irq_hi = 8'h40; irq_req = 8'h60;
        step(); step();
        expect_call("R2", 6);
        insn_bound = 1'b0; vec_ack = 1'b1;
        step();
        vec_ack = 1'b0;
        chk(svc_lo && svc_hi, "R9", "nested flags", int'({svc_hi, svc_lo}), 3);
        irq_req = 8'h20;

        // R3: high handler blocks a new high request
        irq_hi = 8'h48; irq_req = 8'h28; insn_bound = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(vec_req == 1'b0, "R3", "blocked by high", int'(vec_req), 0);
        end

        // R8: return, one boundary gap, then the pending high call
        insn_bound = 1'b0; reti = 1'b1;
        step();
        reti = 1'b0;
        chk(!svc_hi && svc_lo, "R9", "return pops high", int'({svc_hi, svc_lo}), 1);
        insn_bound = 1'b1;
        step();
        chk(vec_req == 1'b0, "R8", "first boundary after return", int'(vec_req), 0);
        step();
        expect_call("R8", 3);

        // R11: hold then withdraw
        insn_bound = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            expect_call("R11", 3);
        end
        irq_req = 8'h20;
        step();
        chk(vec_req == 1'b1, "R11", "withdraw first edge", int'(vec_req), 1);
        step();
        chk(vec_req == 1'b0, "R11", "withdraw second edge", int'(vec_req), 0);

        // R10: global enable gates calls
        glb_en = 1'b0; irq_hi = 8'h50; irq_req = 8'h30; insn_bound = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(vec_req == 1'b0, "R10", "global off", int'(vec_req), 0);
        end
        glb_en = 1'b1;
        step();
        expect_call("R10", 4);
        insn_bound = 1'b0; vec_ack = 1'b1;
        step();
        vec_ack = 1'b0;
        irq_req = '0;

        // R10: disabled source ignored
        irq_en = 8'hFE;
        reti = 1'b1; step(); reti = 1'b0;
        irq_req = 8'h01; irq_hi = 8'h01; insn_bound = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(vec_req == 1'b0, "R10", "disabled source", int'(vec_req), 0);
        end
        irq_en = '1; irq_req = '0; insn_bound = 1'b0;

        // R5: mixed levels at once, clear flags first
        reti = 1'b1; step();
        reti = 1'b0;
        chk(!svc_lo && !svc_hi, "R9", "all returned", int'({svc_hi, svc_lo}), 0);
        irq_req = 8'h82; irq_hi = 8'h80; insn_bound = 1'b1;
        step(); step();
        expect_call("R5", 7);
        insn_bound = 1'b0; vec_ack = 1'b1;
        step();
        vec_ack = 1'b0; irq_req = '0;

        // random phase
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++)
                if ($urandom % 8 == 0) irq_req[i] = ~irq_req[i];
            if ($urandom % 64 == 0) irq_en = N'($urandom);
            if ($urandom % 64 == 0) irq_hi = N'($urandom);
            glb_en     = ($urandom % 16) != 0;
            insn_bound = $urandom % 2 == 0;
            vec_ack    = vec_req && ($urandom % 3 == 0);
            reti       = !vec_ack && (m_lo || m_hs) && ($urandom % 6 == 0);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule